// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Trigger Interrupts

This block holds the two character FIFOs of one UART channel, one for receive and one for transmit, each 64 entries of 8 bits. The serial side pushes received characters and pops characters to send. The host side pops received characters and pushes characters to transmit. A single 8-bit FIFO control register, written by the host, can clear either FIFO. It also stores a DMA-mode flag and selects a fill-level threshold for each direction.

Two interrupt requests come from the fill levels. The receive request is raised while enough characters are waiting. The transmit request is raised when the transmit FIFO drains below its threshold after it had been loaded past that threshold. If the last load never went past the threshold, the request is raised only once the FIFO is empty. The transmit threshold field is writable only while the enhanced-feature enable input is high. Clear commands act on the FIFO pointers and level only, and are never stored.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each FIFO returns characters in the order they were pushed, including across pointer wrap, and reports its fill level (0 to 64) on its level output.
- R2: A push into a full FIFO is discarded and the level stays at 64. The FIFO's overflow output is high for exactly the one cycle after that push.
- R3: A pop from an empty FIFO leaves the level at 0, and the pop data output keeps the last character read. For a successful pop, the data appears on the pop data output in the cycle after the pop.
- R4: In a control write, bit 1 clears the receive FIFO and bit 2 clears the transmit FIFO. Each clear takes effect only if bit 0 is 1 in the same write. A clear sets that FIFO's level to 0 and leaves the other FIFO untouched.
- R5: Control read-back is {rx_sel[7:6], tx_sel[5:4], dma[3], 2'b00, fifo_en[0]}, so the two clear bits always read as 0. The register resets to 8'h00.
- R6: The trigger table becomes active after the first control write made while enh_en_i is 1. Until then, both thresholds are 1. Once active, rx_sel values 00/01/10/11 give receive thresholds 8/16/56/60.
- R7: The tx_sel field, and activation of the trigger table, change only on writes made while enh_en_i is 1. With the table active, tx_sel values 00/01/10/11 give transmit thresholds 8/16/32/56.
- R8: rx_irq_o is high exactly when the receive level is at least the receive threshold. It follows the level in the same cycle.
- R9: A push, or a transmit level above the threshold, drops tx_irq_o on the next clock. If the level went above the threshold since the last request, then once the level falls below the threshold, tx_irq_o rises one clock later.
- R10: If the transmit FIFO was not loaded above its threshold, tx_irq_o stays low as the level drains. It rises one clock after the level reaches 0, and it is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| enh_en_i | input | 1 | Enhanced-feature enable; gates tx_sel and table activation |
| ctrl_rdata_o | output | 8 | Control register read-back |
| rx_push_i | input | 1 | Push a received character |
| rx_push_data_i | input | 8 | Received character |
| rx_pop_i | input | 1 | Host pops a received character |
| rx_pop_data_o | output | 8 | Last popped received character |
| rx_level_o | output | 7 | Receive FIFO fill level |
| rx_ovf_o | output | 1 | Receive overflow pulse |
| rx_irq_o | output | 1 | Receive data-available request |
| tx_push_i | input | 1 | Host pushes a character to transmit |
| tx_push_data_i | input | 8 | Character to transmit |
| tx_pop_i | input | 1 | Transmitter pops a character |
| tx_pop_data_o | output | 8 | Last popped transmit character |
| tx_level_o | output | 7 | Transmit FIFO fill level |
| tx_ovf_o | output | 1 | Transmit overflow pulse |
| tx_irq_o | output | 1 | Transmit-ready request |

## Verification
The receive FIFO is filled across pointer wrap to the receive threshold of 56 and then past full. This separates a level comparison that is off by one from a correct one, and shows that an overflow does not corrupt the stored data. The transmit FIFO is driven through two drain patterns. In the first, a load of 10 characters stays below the threshold of 32 and is drained to empty. In the second, a load of 40 characters is drained through 32 and then 31. Together these separate the "only at empty" rule from the "fell below threshold" rule. Control writes are repeated with and without the enable bit and the enhanced enable. This shows clears that were honoured apart from clears that were ignored, and gated tx_sel writes apart from accepted ones.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned CHAR_W = 8;

  // control register bit positions
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_RX_CLR = 1;
  localparam int unsigned BIT_TX_CLR = 2;
  localparam int unsigned BIT_DMA    = 3;

  function automatic int unsigned rx_trig_lvl(input logic tbl, input logic [1:0] sel);
    if (!tbl) return 1;
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int unsigned tx_trig_lvl(input logic tbl, input logic [1:0] sel);
    if (!tbl) return 1;
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/ufp_fifo.sv
module ufp_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DW     = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    pop_data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic [DW-1:0]    pop_data_q;
  logic             ovf_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty && !clr_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      level_q    <= '0;
      pop_data_q <= '0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_q <= push_i && full && !clr_i;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        level_q  <= '0;
      end else begin
        if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
        if (do_pop) begin
          rd_ptr_q   <= nxt(rd_ptr_q);
          pop_data_q <= mem[rd_ptr_q];
        end
        case ({do_push, do_pop})
          2'b10:   level_q <= level_q + 1'b1;
          2'b01:   level_q <= level_q - 1'b1;
          default: level_q <= level_q;
        endcase
      end
    end
  end

  assign pop_data_o = pop_data_q;
  assign level_o    = level_q;
  assign ovf_o      = ovf_q;

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  assert_ovf_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !clr_i) |=> (ovf_o && level_o == LVL_W'(DEPTH)));
  assert_empty_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !clr_i) |=> ($stable(pop_data_o) && level_o == '0));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (level_o == '0));

endmodule

// File: rtl/ufp_ctrl.sv
module ufp_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  logic             enh_en_i,
  output logic [7:0]       rdata_o,
  output logic             rx_clr_o,
  output logic             tx_clr_o,
  output logic [LVL_W-1:0] rx_trig_o,
  output logic [LVL_W-1:0] tx_trig_o
);

  logic       en_q, dma_q, tbl_q;
  logic [1:0] rx_sel_q, tx_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      dma_q    <= 1'b0;
      tbl_q    <= 1'b0;
      rx_sel_q <= 2'b00;
      tx_sel_q <= 2'b00;
    end else if (we_i) begin
      en_q     <= wdata_i[BIT_EN];
      dma_q    <= wdata_i[BIT_DMA];
      rx_sel_q <= wdata_i[7:6];
      if (enh_en_i) begin
        tx_sel_q <= wdata_i[5:4];
        tbl_q    <= 1'b1;
      end
    end
  end

  // clear strobes are never stored
  assign rx_clr_o  = we_i && wdata_i[BIT_EN] && wdata_i[BIT_RX_CLR];
  assign tx_clr_o  = we_i && wdata_i[BIT_EN] && wdata_i[BIT_TX_CLR];
  assign rdata_o   = {rx_sel_q, tx_sel_q, dma_q, 2'b00, en_q};
  assign rx_trig_o = LVL_W'(rx_trig_lvl(tbl_q, rx_sel_q));
  assign tx_trig_o = LVL_W'(tx_trig_lvl(tbl_q, tx_sel_q));

  assert_tx_sel_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !enh_en_i) |=> $stable(tx_trig_o));

endmodule

// File: rtl/ufp_tx_irq.sv
module ufp_tx_irq #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             irq_o
);

  logic irq_q, filled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b1;
      filled_q <= 1'b0;
    end else begin
      if (level_i > trig_i) filled_q <= 1'b1;
      if (push_i || level_i > trig_i) begin
        irq_q <= 1'b0;
      end else if (level_i == '0 || (filled_q && level_i < trig_i)) begin
        irq_q    <= 1'b1;
        filled_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  assert_tx_irq_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || level_i > trig_i) |=> !irq_o);
  assert_tx_irq_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0 && !push_i) |=> irq_o);

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              enh_en_i,
  output logic [7:0]        ctrl_rdata_o,
  input  logic              rx_push_i,
  input  logic [CHAR_W-1:0] rx_push_data_i,
  input  logic              rx_pop_i,
  output logic [CHAR_W-1:0] rx_pop_data_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              rx_ovf_o,
  output logic              rx_irq_o,
  input  logic              tx_push_i,
  input  logic [CHAR_W-1:0] tx_push_data_i,
  input  logic              tx_pop_i,
  output logic [CHAR_W-1:0] tx_pop_data_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              tx_ovf_o,
  output logic              tx_irq_o
);

  logic             rx_clr, tx_clr;
  logic [LVL_W-1:0] rx_trig, tx_trig;

  ufp_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .enh_en_i  (enh_en_i),
    .rdata_o   (ctrl_rdata_o),
    .rx_clr_o  (rx_clr),
    .tx_clr_o  (tx_clr),
    .rx_trig_o (rx_trig),
    .tx_trig_o (tx_trig)
  );

  ufp_fifo #(.DEPTH(DEPTH), .DW(CHAR_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i       (rx_clr),
    .push_i      (rx_push_i),
    .push_data_i (rx_push_data_i),
    .pop_i       (rx_pop_i),
    .pop_data_o  (rx_pop_data_o),
    .level_o     (rx_level_o),
    .ovf_o       (rx_ovf_o)
  );

  ufp_fifo #(.DEPTH(DEPTH), .DW(CHAR_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i       (tx_clr),
    .push_i      (tx_push_i),
    .push_data_i (tx_push_data_i),
    .pop_i       (tx_pop_i),
    .pop_data_o  (tx_pop_data_o),
    .level_o     (tx_level_o),
    .ovf_o       (tx_ovf_o)
  );

  assign rx_irq_o = (rx_level_o >= rx_trig);

  ufp_tx_irq #(.LVL_W(LVL_W)) u_tx_irq (
    .clk_i, .rst_ni,
    .push_i  (tx_push_i),
    .level_i (tx_level_o),
    .trig_i  (tx_trig),
    .irq_o   (tx_irq_o)
  );

  assert_rx_clr_isolated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clr && !tx_clr && !tx_push_i && !tx_pop_i) |=> $stable(tx_level_o));

endmodule

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic       enh_en_i = 1'b0;
  logic [7:0] ctrl_rdata_o;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] rx_push_data_i = '0, tx_push_data_i = '0;
  logic [7:0] rx_pop_data_o, tx_pop_data_o;
  logic [6:0] rx_level_o, tx_level_o;
  logic       rx_ovf_o, tx_ovf_o, rx_irq_o, tx_irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_pair u_dut (
    .clk_i(clk), .rst_ni,
    .ctrl_we_i, .ctrl_wdata_i, .enh_en_i, .ctrl_rdata_o,
    .rx_push_i, .rx_push_data_i, .rx_pop_i, .rx_pop_data_o, .rx_level_o, .rx_ovf_o, .rx_irq_o,
    .tx_push_i, .tx_push_data_i, .tx_pop_i, .tx_pop_data_o, .tx_level_o, .tx_ovf_o, .tx_irq_o
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] rx_q[$], tx_q[$], rx_exp_q[$], tx_exp_q[$];
  logic [7:0] rx_last = '0, tx_last = '0;
  logic rx_arm = 1'b0, tx_arm = 1'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // monitor: compare popped data against scoreboard
  always @(posedge clk) begin
    rx_arm <= rx_pop_i;
    tx_arm <= tx_pop_i;
  end
  always @(negedge clk) begin
    if (rx_arm && rx_exp_q.size() > 0) begin
      logic [7:0] e;
      e = rx_exp_q.pop_front();
      chk_eq("R1/R3 rx pop data", int'(rx_pop_data_o), int'(e));
    end
    if (tx_arm && tx_exp_q.size() > 0) begin
      logic [7:0] e;
      e = tx_exp_q.pop_front();
      chk_eq("R1/R3 tx pop data", int'(tx_pop_data_o), int'(e));
    end
  end

  task automatic ctrl_wr(input logic [7:0] d, input logic enh);
    ctrl_we_i = 1'b1; ctrl_wdata_i = d; enh_en_i = enh;
    @(negedge clk);
    ctrl_we_i = 1'b0; enh_en_i = 1'b0;
    if (d[0] && d[1]) rx_q.delete();
    if (d[0] && d[2]) tx_q.delete();
  endtask

  task automatic push(input bit is_tx, input logic [7:0] d);
    bit was_full;
    if (is_tx) begin
      was_full = (tx_q.size() == 64);
      tx_push_i = 1'b1; tx_push_data_i = d;
      if (!was_full) tx_q.push_back(d);
    end else begin
      was_full = (rx_q.size() == 64);
      rx_push_i = 1'b1; rx_push_data_i = d;
      if (!was_full) rx_q.push_back(d);
    end
    @(negedge clk);
    tx_push_i = 1'b0; rx_push_i = 1'b0;
    if (was_full) chk_eq("R2 overflow pulse", int'(is_tx ? tx_ovf_o : rx_ovf_o), 1);
  endtask

  task automatic pop(input bit is_tx);
    if (is_tx) begin
      if (tx_q.size() > 0) tx_last = tx_q.pop_front();
      tx_exp_q.push_back(tx_last);
      tx_pop_i = 1'b1;
    end else begin
      if (rx_q.size() > 0) rx_last = rx_q.pop_front();
      rx_exp_q.push_back(rx_last);
      rx_pop_i = 1'b1;
    end
    @(negedge clk);
    tx_pop_i = 1'b0; rx_pop_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk_eq("R5 reset ctrl", int'(ctrl_rdata_o), 'h00);
    chk_eq("R1 reset rx level", int'(rx_level_o), 0);
    chk_eq("R8 reset rx irq", int'(rx_irq_o), 0);
    chk_eq("R10 reset tx irq", int'(tx_irq_o), 1);

    // R6 default threshold 1
    push(0, 8'hA1);
    chk_eq("R6 rx irq at level 1", int'(rx_irq_o), 1);
    push(0, 8'hB2); push(0, 8'hC3);
    chk_eq("R1 rx level 3", int'(rx_level_o), 3);
    for (int i = 0; i < 3; i++) pop(0);
    chk_eq("R8 rx irq empty", int'(rx_irq_o), 0);
    pop(0);  // R3 empty pop keeps last data
    @(negedge clk);
    chk_eq("R3 level after empty pop", int'(rx_level_o), 0);

    // R5/R6/R7 control register
    ctrl_wr(8'h69, 1'b1);
    chk_eq("R5 readback 69", int'(ctrl_rdata_o), 'h69);
    ctrl_wr(8'h91, 1'b0);
    chk_eq("R7 tx_sel gated readback", int'(ctrl_rdata_o), 'hA1);

    // fill rx across wrap, threshold 56 (R6, R8)
    for (int i = 0; i < 64; i++) begin
      push(0, 8'(i * 3 + 1));
      if (i == 54) chk_eq("R8 rx irq at 55", int'(rx_irq_o), 0);
      if (i == 55) chk_eq("R8 rx irq at 56", int'(rx_irq_o), 1);
    end
    chk_eq("R1 rx full level", int'(rx_level_o), 64);
    push(0, 8'hEE);
    chk_eq("R2 level after overflow", int'(rx_level_o), 64);
    @(negedge clk);
    chk_eq("R2 ovf one cycle", int'(rx_ovf_o), 0);
    for (int i = 0; i < 10; i++) pop(0);
    chk_eq("R8 rx irq at 54", int'(rx_irq_o), 0);

    // R4 clear gating
    for (int i = 0; i < 5; i++) push(1, 8'(8'h50 + i));
    pop(1); pop(1);
    ctrl_wr(8'h82, 1'b0);
    chk_eq("R4 no clear without enable", int'(rx_level_o), 54);
    chk_eq("R5 readback A0", int'(ctrl_rdata_o), 'hA0);
    ctrl_wr(8'h83, 1'b0);
    chk_eq("R4 rx cleared", int'(rx_level_o), 0);
    chk_eq("R4 tx untouched", int'(tx_level_o), 3);
    chk_eq("R5 clear bits read 0", int'(ctrl_rdata_o), 'hA1);
    ctrl_wr(8'h85, 1'b0);
    chk_eq("R4 tx cleared", int'(tx_level_o), 0);
    @(negedge clk);
    chk_eq("R10 tx irq after clear", int'(tx_irq_o), 1);

    // R10: load 10 (< threshold 32), drain
    for (int i = 0; i < 10; i++) push(1, 8'(8'h10 + i));
    chk_eq("R9 push drops tx irq", int'(tx_irq_o), 0);
    for (int i = 0; i < 5; i++) pop(1);
    @(negedge clk);
    chk_eq("R10 no irq at 5 without fill", int'(tx_irq_o), 0);
    for (int i = 0; i < 5; i++) pop(1);
    @(negedge clk);
    chk_eq("R10 irq at empty", int'(tx_irq_o), 1);

    // R9: load 40, drain through threshold
    for (int i = 0; i < 40; i++) push(1, 8'(8'h80 + i));
    chk_eq("R9 tx irq low at 40", int'(tx_irq_o), 0);
    for (int i = 0; i < 8; i++) pop(1);
    @(negedge clk);
    chk_eq("R9 no irq at 32", int'(tx_irq_o), 0);
    pop(1);
    @(negedge clk);
    chk_eq("R9 irq at 31", int'(tx_irq_o), 1);
    push(1, 8'h77);
    chk_eq("R9 push clears irq", int'(tx_irq_o), 0);
    while (tx_q.size() > 0) pop(1);
    @(negedge clk);
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule